// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This block is a processor-side interval timer. A free-running up-counter advances by one on every clock in which a tick-enable strobe is high. A compare register holds a target value. When an increment brings the counter onto the target, the block raises a timer interrupt. The interrupt stays raised until software writes the compare register. Writing it always clears the interrupt, whatever the value, and arms the next match at the same time.

A single register port writes and reads both registers, selected by one address bit. A freeze input stops the counter and with it all matches; the count register can still be loaded while frozen. A 3-bit routing input picks which of eight interrupt lines carries the interrupt. A build parameter decides whether a pending status bit is present.

Top module: `cc_timer`

## Requirements
- R1: After a synchronous reset, the count and compare registers are zero, every interrupt line is low, the pending bit is low and the read data is zero.
- R2: On each clock with `tick_en` high, `freeze` low and no count write, the count goes up by one, wrapping from 0xFFFFFFFF to 0x00000000.
- R3: A write with `reg_sel`=0 loads `reg_wdata` into the count at the next edge; it takes precedence over a tick in the same cycle.
- R4: When an increment yields a value equal to the compare register, the interrupt is raised at that edge; loading the count with a value equal to compare does not raise it.
- R5: Once raised, the interrupt stays high over further ticks and matches until the compare register is written.
- R6: A write with `reg_sel`=1 loads compare and lowers the interrupt at that edge for any value written; it also wins over a match that happens in the same cycle.
- R7: While `freeze` is high the count holds, no match can raise the interrupt, and count writes still load the register.
- R8: When `freeze` falls, counting continues from the held value with no increment lost or added.
- R9: `irq_lines` has bit `irq_route` high while the interrupt is raised and all other bits low; with the interrupt low, all eight bits are low. The route is taken at the same edge as the interrupt state.
- R10: With `HAS_PENDING`=1, `tmr_pending` equals the interrupt state; with `HAS_PENDING`=0 it is always low.
- R11: `rd_data` is registered: after each edge it holds the count (`reg_sel`=0) or the compare (`reg_sel`=1) as they stood just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-advance strobe |
| freeze | input | 1 | Disable-count control; holds the count and blocks matches |
| irq_route | input | 3 | Selects the interrupt line that is driven |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects count, 1 selects compare (read and write) |
| reg_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq_lines | output | 8 | One-hot routed timer interrupt |
| tmr_pending | output | 1 | Timer-pending status |

## Verification
All results change at the first clock edge after the inputs that cause them: the count, compare, interrupt, pending bit and routed lines all appear one edge after a tick, write or route change. `rd_data` also settles at that edge, but it shows the register as it stood before the edge, so a written value shows up on a read one edge later. The bench drives inputs on the falling edge and advances its reference model at the rising edge. It compares every output on the next falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  typedef enum logic {
    SEL_COUNT   = 1'b0,
    SEL_COMPARE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/cc_timer_counter.sv
module cc_timer_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_q,
  output logic             inc_fire,
  output logic [CNT_W-1:0] inc_val
);
  // a load suppresses the increment and therefore any match from it
  assign inc_fire = step & ~load;
  assign inc_val  = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (inc_fire) begin
      cnt_q <= inc_val;
    end
  end
endmodule

// File: rtl/cc_timer_match.sv
module cc_timer_match #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             inc_fire,
  input  logic [CNT_W-1:0] inc_val,
  output logic [CNT_W-1:0] cmp_q,
  output logic             irq_d,
  output logic             irq_q
);
  logic hit;

  assign hit = inc_fire && (inc_val == cmp_q);

  // compare write clears and has priority over a simultaneous hit
  always_comb begin
    irq_d = irq_q;
    if (cmp_wr) begin
      irq_d = 1'b0;
    end else if (hit) begin
      irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      if (cmp_wr) begin
        cmp_q <= cmp_wdata;
      end
    end
  end
endmodule

// File: rtl/cc_timer_route.sv
module cc_timer_route #(
  parameter int ROUTE_W = 3,
  localparam int LINES  = 1 << ROUTE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               irq_d,
  input  logic [ROUTE_W-1:0] route,
  output logic [LINES-1:0]   lines_q
);
  logic [LINES-1:0] lines_d;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign lines_d[g] = irq_d && (route == ROUTE_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lines_q <= '0;
    end else begin
      lines_q <= lines_d;
    end
  end
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int ROUTE_W     = 3,
  parameter bit HAS_PENDING = 1'b1,
  localparam int LINES      = 1 << ROUTE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  input  logic               freeze,
  input  logic [ROUTE_W-1:0] irq_route,
  input  logic               reg_wr,
  input  logic               reg_sel,
  input  logic [CNT_W-1:0]   reg_wdata,
  output logic [CNT_W-1:0]   rd_data,
  output logic [LINES-1:0]   irq_lines,
  output logic               tmr_pending
);
  reg_sel_e         sel;
  logic             cnt_wr;
  logic             cmp_wr;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_q;
  logic             inc_fire;
  logic [CNT_W-1:0] inc_val;
  logic             irq_d;
  logic             irq_q;

  assign sel    = reg_sel_e'(reg_sel);
  assign cnt_wr = reg_wr && (sel == SEL_COUNT);
  assign cmp_wr = reg_wr && (sel == SEL_COMPARE);

  cc_timer_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_wr),
    .load_val (reg_wdata),
    .step     (tick_en && !freeze),
    .cnt_q    (cnt_q),
    .inc_fire (inc_fire),
    .inc_val  (inc_val)
  );

  cc_timer_match #(.CNT_W(CNT_W)) u_match (
    .clk       (clk),
    .rst       (rst),
    .cmp_wr    (cmp_wr),
    .cmp_wdata (reg_wdata),
    .inc_fire  (inc_fire),
    .inc_val   (inc_val),
    .cmp_q     (cmp_q),
    .irq_d     (irq_d),
    .irq_q     (irq_q)
  );

  cc_timer_route #(.ROUTE_W(ROUTE_W)) u_route (
    .clk     (clk),
    .rst     (rst),
    .irq_d   (irq_d),
    .route   (irq_route),
    .lines_q (irq_lines)
  );

  if (HAS_PENDING) begin : g_pend
    always_ff @(posedge clk) begin
      if (rst) begin
        tmr_pending <= 1'b0;
      end else begin
        tmr_pending <= irq_d;
      end
    end
  end else begin : g_nopend
    assign tmr_pending = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= (sel == SEL_COMPARE) ? cmp_q : cnt_q;
    end
  end
endmodule

// File: rtl/cc_timer_checker.sv
module cc_timer_checker #(
  parameter int CNT_W       = 32,
  parameter int ROUTE_W     = 3,
  parameter bit HAS_PENDING = 1'b1,
  localparam int LINES      = 1 << ROUTE_W
) (
  input logic               clk,
  input logic               rst,
  input logic               tick_en,
  input logic               freeze,
  input logic               reg_wr,
  input logic               reg_sel,
  input logic [CNT_W-1:0]   reg_wdata,
  input logic [CNT_W-1:0]   cnt_q,
  input logic               irq_q,
  input logic [LINES-1:0]   irq_lines,
  input logic               tmr_pending
);
  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !freeze && !reg_wr) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  assert_count_load_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_sel) |=> cnt_q == $past(reg_wdata));

  assert_irq_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !(reg_wr && reg_sel)) |=> irq_q);

  assert_cmp_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel) |=> !irq_q);

  assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (freeze && !reg_wr) |=> $stable(cnt_q));

  assert_freeze_nomatch_R7: assert property (@(posedge clk) disable iff (rst)
    (freeze && !irq_q) |=> !irq_q);

  assert_route_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_lines) && ((irq_lines != '0) == irq_q));

  assert_pending_R10: assert property (@(posedge clk) disable iff (rst)
    tmr_pending == (HAS_PENDING ? irq_q : 1'b0));
endmodule

bind cc_timer cc_timer_checker #(
  .CNT_W(CNT_W), .ROUTE_W(ROUTE_W), .HAS_PENDING(HAS_PENDING)
) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .freeze(freeze),
  .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .cnt_q(cnt_q), .irq_q(irq_q), .irq_lines(irq_lines),
  .tmr_pending(tmr_pending)
);

// File: tb/test_cc_timer.sv
module test_cc_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        freeze = 1'b0;
  logic [2:0]  irq_route = 3'd0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rd_data, rd_data_np;
  logic [7:0]  irq_lines, irq_lines_np;
  logic        tmr_pending, tmr_pending_np;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  // reference model state
  logic [31:0] m_cnt = '0, m_cmp = '0, m_rd = '0;
  logic        m_irq = 1'b0;
  logic [7:0]  m_lines = '0;

  always #10 clk = ~clk;

  cc_timer i_cc_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en), .freeze(freeze),
    .irq_route(irq_route), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .rd_data(rd_data), .irq_lines(irq_lines),
    .tmr_pending(tmr_pending)
  );

  cc_timer #(.HAS_PENDING(1'b0)) i_cc_timer_nopend (
    .clk(clk), .rst(rst), .tick_en(tick_en), .freeze(freeze),
    .irq_route(irq_route), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .rd_data(rd_data_np), .irq_lines(irq_lines_np),
    .tmr_pending(tmr_pending_np)
  );

  always @(posedge clk) begin
    logic        inc;
    logic [31:0] nxt;
    cycles++;
    if (rst) begin
      m_cnt = '0; m_cmp = '0; m_rd = '0; m_irq = 1'b0; m_lines = '0;
    end else begin
      inc = tick_en && !freeze && !(reg_wr && !reg_sel);
      nxt = m_cnt + 32'd1;
      m_rd = reg_sel ? m_cmp : m_cnt;
      if (reg_wr && reg_sel) m_irq = 1'b0;
      else if (inc && nxt == m_cmp) m_irq = 1'b1;
      if (reg_wr && !reg_sel) m_cnt = reg_wdata;
      else if (inc) m_cnt = nxt;
      if (reg_wr && reg_sel) m_cmp = reg_wdata;
      m_lines = m_irq ? (8'd1 << irq_route) : 8'd0;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("rd_data", rd_data, m_rd);
    chk("irq_lines", {24'd0, irq_lines}, {24'd0, m_lines});
    chk("pending", {31'd0, tmr_pending}, {31'd0, m_irq});
    chk("np_lines", {24'd0, irq_lines_np}, {24'd0, m_lines});
    chk("np_pending", {31'd0, tmr_pending_np}, 32'd0);
  endtask

  // one cycle: set inputs at the falling edge, compare at the next falling edge
  task automatic cyc(input logic t, input logic fz, input logic wr,
                     input logic sel, input logic [31:0] d, input logic [2:0] rt);
    tick_en = t; freeze = fz; reg_wr = wr; reg_sel = sel; reg_wdata = d; irq_route = rt;
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<50000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    compare_all();
    cyc(0, 0, 0, 0, 0, 0);                 // R1 read count after reset
    cur_req = "R11";
    cyc(0, 0, 0, 1, 0, 0);                 // R11 read compare
    cur_req = "R2";
    cyc(0, 0, 1, 1, 32'h100, 0);           // move compare out of the way
    repeat (5) cyc(1, 0, 0, 0, 0, 0);      // R2 count 1..5
    cyc(0, 0, 0, 0, 0, 0);
    chk("R2 count 5", rd_data, 32'd5);
    cyc(0, 0, 1, 0, 32'hFFFF_FFFE, 0);
    repeat (3) cyc(1, 0, 0, 0, 0, 0);      // R2 wrap to 1
    cyc(0, 0, 0, 0, 0, 0);
    chk("R2 wrap", rd_data, 32'd1);
    cur_req = "R3";
    cyc(1, 0, 1, 0, 32'h50, 0);            // R3 write beats tick
    cyc(0, 0, 0, 0, 0, 0);
    chk("R3 load", rd_data, 32'h50);
    cur_req = "R4";
    cyc(0, 0, 1, 1, 32'h60, 2);
    cyc(0, 0, 1, 0, 32'h60, 2);            // R4 load equal to compare: no irq
    cyc(0, 0, 0, 0, 0, 2);
    chk("R4 no irq on load", {31'd0, tmr_pending}, 32'd0);
    cyc(0, 0, 1, 0, 32'h5E, 2);
    cyc(1, 0, 0, 0, 0, 2);
    cyc(1, 0, 0, 0, 0, 2);                 // R4 hits 0x60
    chk("R4 irq line 2", {24'd0, irq_lines}, 32'h4);
    cur_req = "R5";
    repeat (4) cyc(1, 0, 0, 0, 0, 2);
    chk("R5 sticky", {31'd0, tmr_pending}, 32'd1);
    cur_req = "R9";
    for (int r = 0; r < 8; r++) begin
      cyc(0, 0, 0, 0, 0, 3'(r));
      chk("R9 route", {24'd0, irq_lines}, 32'd1 << r);
    end
    cur_req = "R6";
    cyc(0, 0, 1, 1, 32'h60, 5);            // R6 same value still clears
    chk("R6 clear", {24'd0, irq_lines}, 32'd0);
    cyc(0, 0, 1, 0, 32'h1FF, 5);
    cyc(0, 0, 1, 1, 32'h200, 5);
    cyc(1, 0, 1, 1, 32'h300, 5);           // R6 hit and compare write together
    chk("R6 clear wins", {31'd0, tmr_pending}, 32'd0);
    cur_req = "R7";
    cyc(0, 0, 1, 0, 32'h2FE, 1);
    repeat (6) cyc(1, 1, 0, 0, 0, 1);      // R7 frozen
    chk("R7 hold", rd_data, 32'h2FE);
    cyc(1, 1, 1, 0, 32'h2FF, 1);           // R7 load while frozen
    repeat (3) cyc(1, 1, 0, 0, 0, 1);      // would match 0x300 if running
    chk("R7 no match", {24'd0, irq_lines}, 32'd0);
    chk("R7 frozen load", rd_data, 32'h2FF);
    cur_req = "R8";
    cyc(1, 0, 0, 0, 0, 1);                 // R8 first tick hits 0x300
    chk("R8 resume match", {24'd0, irq_lines}, 32'h2);
    repeat (2) cyc(1, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R8 resume count", rd_data, 32'h302);
    cur_req = "R11";
    cyc(0, 0, 1, 1, 32'hABCD, 0);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R11 read compare", rd_data, 32'hABCD);
    cur_req = "R10";
    for (int i = 0; i < 400; i++) begin
      logic [31:0] v = $urandom;
      logic w = ($urandom % 8) == 0;
      logic s = $urandom % 2;
      if (w && !s) v = m_cmp - ($urandom % 4);
      cyc(($urandom % 4) != 0, ($urandom % 8) == 0, w, s, v, 3'($urandom));
    end
    rst = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    compare_all();
    rst = 1'b0;
    finish_run();
  end
endmodule